// File: doc/BRIEF.md
# Slave-Mode Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. An external source drives the bit clock, the frame clock and the serial data. The block brings all three into the system clock domain through synchronisers, detects the chosen bit-clock edge, and shifts the data in MSB first. It delivers a left and a right sample, each left-justified in a 32-bit register, and gives a one-cycle valid pulse when the right sample of a frame is complete.

Run-time controls set four things:
- which bit-clock edge samples the data;
- which frame-clock level marks the left channel;
- the word length;
- the framing, which is either level framing (the frame clock level names the channel) or pulse framing (a sync edge starts a left word and a right word sent back to back). Each framing can be used with or without a one-bit delay.

Top module: `sar_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: With `cfg_strobe_rise_i` = 0, data and frame are sampled on the falling bit-clock edge, so the source must change them after the rising edge. With `cfg_strobe_rise_i` = 1 the edges swap.
- R3: With `cfg_left_hi_i` = 1, a high frame clock marks the left channel. With 0, a low frame clock marks it.
- R4: `cfg_len_i` selects the word length: 00 gives 16 bits, 01 gives 20, 10 gives 24 and 11 gives 32. Bits arrive MSB first. Each word is placed in bits 31 and down of its output, and the unused low bits are zero.
- R5: Slot bits that arrive after the selected word length has been received have no effect on the outputs.
- R6: With `cfg_fmt_i[1]` = 0 (level framing), every change of the sampled frame level starts a word for the channel that the new level marks. With `cfg_fmt_i[0]` = 0 the MSB is sampled one bit period after the change. With `cfg_fmt_i[0]` = 1 the MSB is sampled in the same bit period as the change.
- R7: With `cfg_fmt_i[1]` = 1 (pulse framing), a change of the frame clock into the left level starts a frame, and a change out of it is ignored. The left word follows, with the MSB placement set by `cfg_fmt_i[0]` as in R6. The right word follows the left word with no gap.
- R8: `valid_o` is a one-cycle pulse that marks a completed right word. `right_o` changes only in the cycle in which `valid_o` is high.
- R9: If a frame-level change arrives before a word is complete, the partial word is dropped. The counter restarts for the new channel, and that channel's output keeps its earlier value.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| fclk_i | input | 1 | Frame clock / frame sync (asynchronous) |
| sdata_i | input | 1 | Serial audio data (asynchronous) |
| cfg_strobe_rise_i | input | 1 | 1: sample on rising bit-clock edge, 0: falling |
| cfg_left_hi_i | input | 1 | 1: frame high marks left, 0: frame low marks left |
| cfg_len_i | input | 2 | Word length code (16/20/24/32) |
| cfg_fmt_i | input | 2 | Bit 1: pulse framing; bit 0: no one-bit delay |
| left_o | output | 32 | Last completed left word, left-justified |
| right_o | output | 32 | Last completed right word, left-justified |
| valid_o | output | 1 | One-cycle pulse after each right word |

## Verification
The assertions assume that the bit clock runs at no more than a quarter of the system clock. As a result, two synchronised bit-clock edges never fall on adjacent cycles, and many sampling edges lie between two completed right words. They also assume that the length control stays fixed while a word is being received.

The stimulus keeps within these limits. It uses a bit period of eight system clocks and changes the controls only in idle gaps between frames. Within each bit period it places data and frame mid-period and corrupts the data after the sampling edge, so sampling on the wrong edge gives wrong words.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_SKIP = 2'd1,
        RX_RECV = 2'd2
    } rx_state_e;

    localparam logic CH_LEFT  = 1'b0;
    localparam logic CH_RIGHT = 1'b1;

    function automatic int word_len(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 20;
            2'b10:   return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[s] <= '0;
                else         stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[s] <= '0;
                else         stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sar_edge.sv
module sar_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bclk_s_i,
    input  logic rise_sel_i,
    output logic stb_o,
    output logic any_o
);

    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d = bclk_s_i;
        rise   = bclk_s_i & ~prev_q;
        fall   = ~bclk_s_i & prev_q;
        stb_o  = rise_sel_i ? rise : fall;
        any_o  = rise | fall;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

endmodule

// File: rtl/sar_deser.sv
module sar_deser #(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          stb_i,
    input  logic          frame_i,
    input  logic          data_i,
    input  logic          left_hi_i,
    input  logic [1:0]    len_i,
    input  logic [1:0]    fmt_i,
    output logic [DW-1:0] left_o,
    output logic [DW-1:0] right_o,
    output logic          valid_o
);
    import sar_pkg::*;

    localparam int CNT_W = $clog2(DW + 1);

    typedef struct packed {
        rx_state_e        st;
        logic             ch;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    sh;
        logic             fprev;
        logic             primed;
        logic [DW-1:0]    left;
        logic [DW-1:0]    right;
        logic             valid;
    } deser_t;

    deser_t r_d, r_q;

    logic             pulse_mode, no_delay, is_left, chg, start, take;
    logic             ch_cur;
    logic [CNT_W-1:0] base_cnt, cnt_nxt;
    logic [DW-1:0]    sh_nxt, word;
    int               wlen;

    always_comb begin
        r_d        = r_q;
        r_d.valid  = 1'b0;
        pulse_mode = fmt_i[1];
        no_delay   = fmt_i[0];
        wlen       = word_len(len_i);
        is_left    = (frame_i == left_hi_i);
        chg        = r_q.primed && (frame_i != r_q.fprev);
        start      = 1'b0;
        take       = 1'b0;
        ch_cur     = r_q.ch;
        base_cnt   = r_q.cnt;
        sh_nxt     = {r_q.sh[DW-2:0], data_i};
        cnt_nxt    = '0;
        word       = '0;

        if (stb_i) begin
            r_d.fprev  = frame_i;
            r_d.primed = 1'b1;
            start      = chg && (!pulse_mode || is_left);

            if (start) begin
                ch_cur   = (pulse_mode || is_left) ? CH_LEFT : CH_RIGHT;
                base_cnt = '0;
                r_d.ch   = ch_cur;
                r_d.cnt  = '0;
                if (no_delay) take = 1'b1;
                else          r_d.st = RX_SKIP;
            end else if (r_q.st != RX_IDLE) begin
                take = 1'b1;
            end

            if (take) begin
                cnt_nxt = base_cnt + CNT_W'(1);
                r_d.sh  = sh_nxt;
                r_d.cnt = cnt_nxt;
                r_d.st  = RX_RECV;
                if (int'(cnt_nxt) == wlen) begin
                    word = sh_nxt << (DW - wlen);
                    if (ch_cur == CH_LEFT) begin
                        r_d.left = word;
                        if (pulse_mode) begin
                            r_d.ch  = CH_RIGHT;
                            r_d.cnt = '0;
                            r_d.st  = RX_RECV;
                        end else begin
                            r_d.st = RX_IDLE;
                        end
                    end else begin
                        r_d.right = word;
                        r_d.valid = 1'b1;
                        r_d.st    = RX_IDLE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st     <= RX_IDLE;
            r_q.ch     <= CH_LEFT;
            r_q.cnt    <= '0;
            r_q.sh     <= '0;
            r_q.fprev  <= 1'b0;
            r_q.primed <= 1'b0;
            r_q.left   <= '0;
            r_q.right  <= '0;
            r_q.valid  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign left_o  = r_q.left;
    assign right_o = r_q.right;
    assign valid_o = r_q.valid;

endmodule

// File: rtl/sar_rx.sv
module sar_rx #(
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          bclk_i,
    input  logic          fclk_i,
    input  logic          sdata_i,
    input  logic          cfg_strobe_rise_i,
    input  logic          cfg_left_hi_i,
    input  logic [1:0]    cfg_len_i,
    input  logic [1:0]    cfg_fmt_i,
    output logic [DW-1:0] left_o,
    output logic [DW-1:0] right_o,
    output logic          valid_o
);

    localparam int NSIG = 3;

    logic [NSIG-1:0] pins_s;
    logic            smp_stb, bclk_edge;

    sar_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({bclk_i, fclk_i, sdata_i}),
        .sync_o  (pins_s)
    );

    sar_edge u_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bclk_s_i   (pins_s[2]),
        .rise_sel_i (cfg_strobe_rise_i),
        .stb_o      (smp_stb),
        .any_o      (bclk_edge)
    );

    sar_deser #(.DW(DW)) u_deser (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stb_i     (smp_stb),
        .frame_i   (pins_s[1]),
        .data_i    (pins_s[0]),
        .left_hi_i (cfg_left_hi_i),
        .len_i     (cfg_len_i),
        .fmt_i     (cfg_fmt_i),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o)
    );

endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk #(
    parameter int DW = 32
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          smp_stb,
    input logic          bclk_edge,
    input logic [1:0]    cfg_len_i,
    input logic [DW-1:0] left_o,
    input logic [DW-1:0] right_o,
    input logic          valid_o
);
    import sar_pkg::*;

    logic [DW-1:0] tail_mask;
    always_comb tail_mask = (DW'(1) << (DW - word_len(cfg_len_i))) - DW'(1);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o); // R8

    AST_RIGHT_ONLY_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(right_o) |-> valid_o); // R8

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(smp_stb)); // R2

    AST_BCLK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bclk_edge |=> !bclk_edge); // R2

    AST_TAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $stable(cfg_len_i)) |-> ((right_o & tail_mask) == '0)); // R4

    AST_LEFT_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(left_o) |-> $past(smp_stb)); // R6

endmodule

bind sar_rx sar_rx_chk #(.DW(DW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_stb   (smp_stb),
    .bclk_edge (bclk_edge),
    .cfg_len_i (cfg_len_i),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
);

// File: tb/sim_sar_rx.sv
`timescale 1ns/1ps
module sim_sar_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1;
    logic        fclk = 1'b0;
    logic        sdata = 1'b0;
    logic        esel = 1'b0;
    logic        lhi = 1'b0;
    logic [1:0]  len_c = 2'b10;
    logic [1:0]  fmt = 2'b00;
    logic [31:0] left_w, right_w;
    logic        valid;

    int checks = 0;
    int fails = 0;
    int vcount = 0;
    logic prev_valid = 1'b0;
    logic [31:0] exp_left = '0;
    logic [31:0] exp_right = '0;

    always #2.5 clk = ~clk;

    sar_rx u0 (
        .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fclk_i(fclk), .sdata_i(sdata),
        .cfg_strobe_rise_i(esel), .cfg_left_hi_i(lhi), .cfg_len_i(len_c), .cfg_fmt_i(fmt),
        .left_o(left_w), .right_o(right_w), .valid_o(valid)
    );

    // Monitor: count valid pulses, and flag any pulse longer than one cycle (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid) begin
                vcount++;
                checks++;
                if (prev_valid) begin
                    fails++;
                    $display("FAIL R8 valid width: actual 2+ cycles expected 1");
                end
            end
            prev_valid = valid;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int lenof(input logic [1:0] c);
        case (c)
            2'b00: return 16;
            2'b01: return 20;
            2'b10: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] ljust(input logic [31:0] w, input int n);
        logic [63:0] m;
        m = (64'd1 << n) - 64'd1;
        return 32'((({32'd0, w} & m) << (32 - n)));
    endfunction

    // One bit period: launch edge, mid-period data, sampling edge, then data corrupted
    task automatic bitp(input logic f, input logic d);
        bclk = esel ? 1'b0 : 1'b1;
        #10; fclk = f; sdata = d;
        #10; bclk = esel ? 1'b1 : 1'b0;
        #10; sdata = ~d;
        #10;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bitp(~lhi, 1'b0);
    endtask

    // Level framing (R6): lslot periods of left level, rslot of right level
    task automatic level_frame(input logic [31:0] lw, input logic [31:0] rw,
                               input int lslot, input int rslot);
        int n;
        int b;
        n = lenof(len_c);
        for (int i = 0; i < lslot; i++) begin
            b = fmt[0] ? i : i - 1;
            bitp(lhi, (b >= 0 && b < n) ? lw[n-1-b] : 1'b1);
        end
        for (int i = 0; i < rslot; i++) begin
            b = fmt[0] ? i : i - 1;
            bitp(~lhi, (b >= 0 && b < n) ? rw[n-1-b] : 1'b1);
        end
        idle(2);
    endtask

    // Pulse framing (R7): one-period sync, then left and right back to back
    task automatic pulse_frame(input logic [31:0] lw, input logic [31:0] rw);
        int n;
        int b;
        logic d;
        n = lenof(len_c);
        for (int i = 0; i < 2 * n + 4; i++) begin
            b = fmt[0] ? i : i - 1;
            if (b >= 0 && b < n)          d = lw[n-1-b];
            else if (b >= n && b < 2 * n) d = rw[n-1-(b-n)];
            else                          d = 1'b1;
            bitp((i == 0) ? lhi : ~lhi, d);
        end
        idle(2);
    endtask

    task automatic set_cfg(input logic e, input logic l, input logic [1:0] lc, input logic [1:0] f);
        esel = e; lhi = l; len_c = lc; fmt = f;
        fclk = ~l;
        bclk = e ? 1'b1 : 1'b0;
        #80;
        idle(3);
    endtask

    task automatic expect_frame(input string tag, input int v0,
                                input logic [31:0] lw, input logic [31:0] rw, input bit left_new);
        repeat (20) @(negedge clk);
        if (left_new) exp_left = ljust(lw, lenof(len_c));
        exp_right = ljust(rw, lenof(len_c));
        chk({tag, " valid count"}, 32'(vcount - v0), 32'd1);
        chk({tag, " left"}, left_w, exp_left);
        chk({tag, " right"}, right_w, exp_right);
    endtask

    task automatic t_reset;
        #1;
        chk("R1 left at reset", left_w, '0);
        chk("R1 right at reset", right_w, '0);
        chk("R1 valid at reset", {31'd0, valid}, '0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 valid after release", {31'd0, valid}, '0);
        chk("R1 left after release", left_w, '0);
    endtask

    // R6 R2 R3 R4 R5: level framing with one-bit delay, 24 bits, falling-edge sampling, left low
    task automatic t_level_dly24;
        int v0;
        set_cfg(1'b0, 1'b0, 2'b10, 2'b00);
        v0 = vcount;
        level_frame(32'h00A5C3E1, 32'h005A3C1E, 32, 32);
        expect_frame("R6/R4/R5 level dly 24", v0, 32'h00A5C3E1, 32'h005A3C1E, 1);
    endtask

    // R6 R2 R3: no delay, 16 bits, rising-edge sampling, left high
    task automatic t_level_nodly16;
        int v0;
        set_cfg(1'b1, 1'b1, 2'b00, 2'b01);
        v0 = vcount;
        level_frame(32'h0000BEEF, 32'h00001234, 32, 32);
        expect_frame("R6/R2/R3 level nodly 16", v0, 32'h0000BEEF, 32'h00001234, 1);
    endtask

    // R7: pulse framing, delayed, 20 bits
    task automatic t_pulse_dly20;
        int v0;
        set_cfg(1'b0, 1'b1, 2'b01, 2'b10);
        v0 = vcount;
        pulse_frame(32'h000ABCDE, 32'h00054321);
        expect_frame("R7 pulse dly 20", v0, 32'h000ABCDE, 32'h00054321, 1);
    endtask

    // R7 R4: pulse framing, non-delayed, 32 bits, rising-edge sampling, left low
    task automatic t_pulse_nodly32;
        int v0;
        set_cfg(1'b1, 1'b0, 2'b11, 2'b11);
        v0 = vcount;
        pulse_frame(32'hDEADBEEF, 32'h80000001);
        expect_frame("R7/R4 pulse nodly 32", v0, 32'hDEADBEEF, 32'h80000001, 1);
    endtask

    // R4 R6: level framing, delayed, 32 bits in a 34-period slot
    task automatic t_level_dly32;
        int v0;
        set_cfg(1'b0, 1'b1, 2'b11, 2'b00);
        v0 = vcount;
        level_frame(32'hC0FFEE01, 32'h7E57AB1E, 34, 34);
        expect_frame("R4/R6 level dly 32", v0, 32'hC0FFEE01, 32'h7E57AB1E, 1);
    endtask

    // R9: left slot cut short, so left keeps its previous value
    task automatic t_restart;
        int v0;
        set_cfg(1'b0, 1'b0, 2'b10, 2'b00);
        v0 = vcount;
        level_frame(32'h00111111, 32'h00222222, 32, 32);
        expect_frame("R9 setup frame", v0, 32'h00111111, 32'h00222222, 1);
        v0 = vcount;
        level_frame(32'h00FFFFFF, 32'h00333333, 10, 32);
        expect_frame("R9 truncated left", v0, 32'h0, 32'h00333333, 0);
    endtask

    initial begin
        t_reset();
        t_level_dly24();
        t_level_nodly16();
        t_pulse_dly20();
        t_pulse_nodly32();
        t_level_dly32();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule